// File: doc/BRIEF.md
# Wide Register Transfer Splitter

This block lets a host reach a register that is wider than the data bus. The host gives one request: a base address, the register size in bytes and, for a write, the full register value. The block then runs the bus-width transfers that the request needs on a simple bus master port. That port has one transfer outstanding at a time and uses a valid/ready handshake. For a read, it collects the returned words into one wide value and reports it with a single-cycle done pulse.

The bus is `BUS_BYTES` byte lanes wide. Lane k is bits [8k+7:8k] of a bus word. Transfers always go out in increasing address order. A static parameter, `BIG_ENDIAN`, sets which register byte each address byte holds:
- **Little-endian:** the least-significant word sits at the base address, and lane 0 holds the least-significant byte of each word.
- **Big-endian:** the mapping is fully reversed. Address byte j holds register byte T-1-j, where T is the number of bytes transferred.

Only aligned registers are supported, with a size that is a whole multiple of the bus width. A register of one bus word or less takes exactly one full-word transfer. Its unused upper bytes come from the low bytes of the host data.

The control is a three-state machine:
- **IDLE:** the block waits. A host request moves it to XFER.
- **XFER:** `bus_valid` is high. The block stays in XFER through wait states and through accepted transfers that are not the last. When the last transfer is accepted it moves to DONE.
- **DONE:** the block raises `done` for one cycle and always returns to IDLE on the next cycle.

Top module: `wide_reg_splitter`

## Requirements
- R1: After reset, `busy`, `bus_valid` and `done` are all 0.
- R2: A request of N bytes makes exactly N/`BUS_BYTES` bus transfers, capped at `MAX_WORDS`. A request of `BUS_BYTES` bytes or fewer makes exactly one. `bus_write` equals the request's write flag on every one of them.
- R3: Transfer k uses address base + k·`BUS_BYTES`, for k = 0, 1, …. Addresses rise in this order in both endianness modes.
- R4: Little-endian write: on transfer k, lane i (bus bits [8i+7:8i]) carries host byte k·`BUS_BYTES`+i. Host byte j is `req_wdata`[8j+7:8j].
- R5: Big-endian write: on transfer k, lane i carries host byte T-1-(k·`BUS_BYTES`+i), where T = number of transfers × `BUS_BYTES`.
- R6: Read: each returned lane is stored at the byte position that R4 or R5 gives for the current mode. Bytes at or above T read as zero. `rd_data` holds the result, valid from the done cycle until the next request.
- R7: While `busy` is high, `req_valid` is ignored and no extra transfer is started. `bus_valid` is never high while `busy` is low.
- R8: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_wdata` and `bus_write` stay unchanged in the next cycle.
- R9: `done` is high for exactly one cycle, the cycle after the last transfer is accepted, for both reads and writes.
- R10: A request seen while idle makes `busy` and `bus_valid` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request strobe, taken only while idle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Base byte address of the register (aligned) |
| req_bytes | input | $clog2(BUS_BYTES*MAX_WORDS+1) | Register size in bytes |
| req_wdata | input | 8*BUS_BYTES*MAX_WORDS | Register value to write, byte j at bits [8j+7:8j] |
| busy | output | 1 | High while a sequence is running |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8*BUS_BYTES*MAX_WORDS | Assembled read result |
| bus_valid | output | 1 | Bus transfer request |
| bus_write | output | 1 | Bus transfer direction |
| bus_addr | output | ADDR_W | Bus transfer byte address |
| bus_wdata | output | 8*BUS_BYTES | Bus write data, lane k at bits [8k+7:8k] |
| bus_ready | input | 1 | Bus accepts the current transfer |
| bus_rdata | input | 8*BUS_BYTES | Bus read data, valid in the accepting cycle |

## Verification
Some properties are checked by assertions on every cycle:
- the bus request holds steady across wait states;
- each accepted transfer is followed by the next address one bus word higher;
- `done` is a lone pulse that comes straight after an accepted transfer;
- `bus_valid` never appears outside `busy`.

The lane-to-byte mapping in each endianness mode, the exact transfer count, the read gathering and the placement of bytes in memory can only be shown by the bench scenarios. These scenarios run one little-endian instance and one big-endian instance side by side. They also cover the case where a request arriving mid-sequence must leave memory untouched.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } wrs_state_e;
endpackage

// File: rtl/wrs_seq_fsm.sv
module wrs_seq_fsm
    import wrs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic accept,
    input  logic last_word,
    output logic load,
    output logic advance,
    output logic busy,
    output logic bus_valid,
    output logic done
);
    wrs_state_e state_q, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (start)               state_nx = ST_XFER;
            ST_XFER: if (accept && last_word) state_nx = ST_DONE;
            ST_DONE:                          state_nx = ST_IDLE;
            default:                          state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load      = 1'b0;
        advance   = 1'b0;
        busy      = 1'b1;
        bus_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_XFER: begin
                bus_valid = 1'b1;
                advance   = accept;
            end
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/wrs_word_ctr.sv
module wrs_word_ctr #(
    parameter int BUS_BYTES = 4,
    parameter int MAX_WORDS = 4,
    parameter int ADDR_W    = 16,
    parameter int BSZ_W     = 5,
    parameter int WCNT_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BSZ_W-1:0]  req_bytes,
    output logic [WCNT_W-1:0] word_idx,
    output logic [WCNT_W-1:0] nwords,
    output logic              last_word,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int LANE_SH = $clog2(BUS_BYTES);

    logic [ADDR_W-1:0] base_q;
    logic [BSZ_W-1:0]  shifted;
    logic [WCNT_W-1:0] req_words;

    assign shifted = req_bytes >> LANE_SH;

    always_comb begin
        if (req_bytes <= BSZ_W'(BUS_BYTES))
            req_words = WCNT_W'(1);
        else if (shifted > BSZ_W'(MAX_WORDS))
            req_words = WCNT_W'(MAX_WORDS);
        else
            req_words = WCNT_W'(shifted);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            nwords   <= WCNT_W'(1);
            word_idx <= '0;
        end else if (load) begin
            base_q   <= req_addr;
            nwords   <= req_words;
            word_idx <= '0;
        end else if (advance) begin
            word_idx <= word_idx + WCNT_W'(1);
        end
    end

    assign last_word = (word_idx == nwords - WCNT_W'(1));
    assign cur_addr  = base_q + (ADDR_W'(word_idx) << LANE_SH);
endmodule

// File: rtl/wrs_lane_map.sv
module wrs_lane_map #(
    parameter int BUS_BYTES  = 4,
    parameter int BIG_ENDIAN = 0,
    parameter int WCNT_W     = 3,
    parameter int BIDX_W     = 4
) (
    input  logic [WCNT_W-1:0]           word_idx,
    input  logic [WCNT_W-1:0]           nwords,
    output logic [BUS_BYTES*BIDX_W-1:0] lane_idx
);
    localparam int LANE_SH = $clog2(BUS_BYTES);
    localparam int PW      = BIDX_W + 2;

    logic [PW-1:0] first_pos;
    logic [PW-1:0] span;

    assign first_pos = PW'(word_idx) << LANE_SH;
    assign span      = PW'(nwords) << LANE_SH;

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
        logic [PW-1:0] pos;
        assign pos = first_pos + PW'(i);
        if (BIG_ENDIAN != 0) begin : g_big
            assign lane_idx[i*BIDX_W +: BIDX_W] = BIDX_W'(span - pos - PW'(1));
        end else begin : g_little
            assign lane_idx[i*BIDX_W +: BIDX_W] = BIDX_W'(pos);
        end
    end
endmodule

// File: rtl/wrs_gather.sv
module wrs_gather #(
    parameter int BUS_BYTES = 4,
    parameter int REG_BYTES = 16,
    parameter int BIDX_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic                        capture,
    input  logic [BUS_BYTES*BIDX_W-1:0] lane_idx,
    input  logic [BUS_BYTES*8-1:0]      bus_rdata,
    output logic [REG_BYTES*8-1:0]      rd_data
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_data <= '0;
        end else if (capture) begin
            for (int i = 0; i < BUS_BYTES; i++)
                rd_data[lane_idx[i*BIDX_W +: BIDX_W]*8 +: 8] <= bus_rdata[i*8 +: 8];
        end
    end
endmodule

// File: rtl/wide_reg_splitter.sv
module wide_reg_splitter #(
    parameter int BUS_BYTES  = 4,
    parameter int MAX_WORDS  = 4,
    parameter int ADDR_W     = 16,
    parameter int BIG_ENDIAN = 0
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      req_valid,
    input  logic                                      req_write,
    input  logic [ADDR_W-1:0]                         req_addr,
    input  logic [$clog2(BUS_BYTES*MAX_WORDS+1)-1:0]  req_bytes,
    input  logic [8*BUS_BYTES*MAX_WORDS-1:0]          req_wdata,
    output logic                                      busy,
    output logic                                      done,
    output logic [8*BUS_BYTES*MAX_WORDS-1:0]          rd_data,
    output logic                                      bus_valid,
    output logic                                      bus_write,
    output logic [ADDR_W-1:0]                         bus_addr,
    output logic [8*BUS_BYTES-1:0]                    bus_wdata,
    input  logic                                      bus_ready,
    input  logic [8*BUS_BYTES-1:0]                    bus_rdata
);
    localparam int REG_BYTES = BUS_BYTES * MAX_WORDS;
    localparam int REG_W     = 8 * REG_BYTES;
    localparam int BSZ_W     = $clog2(REG_BYTES + 1);
    localparam int WCNT_W    = $clog2(MAX_WORDS + 1);
    localparam int BIDX_W    = $clog2(REG_BYTES);

    logic                        load, advance, last_word;
    logic [WCNT_W-1:0]           word_idx, nwords;
    logic [BUS_BYTES*BIDX_W-1:0] lane_idx;
    logic [REG_W-1:0]            wdata_q;
    logic                        write_q;

    wrs_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (req_valid),
        .accept    (bus_ready),
        .last_word (last_word),
        .load      (load),
        .advance   (advance),
        .busy      (busy),
        .bus_valid (bus_valid),
        .done      (done)
    );

    wrs_word_ctr #(
        .BUS_BYTES (BUS_BYTES),
        .MAX_WORDS (MAX_WORDS),
        .ADDR_W    (ADDR_W),
        .BSZ_W     (BSZ_W),
        .WCNT_W    (WCNT_W)
    ) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .advance   (advance),
        .req_addr  (req_addr),
        .req_bytes (req_bytes),
        .word_idx  (word_idx),
        .nwords    (nwords),
        .last_word (last_word),
        .cur_addr  (bus_addr)
    );

    wrs_lane_map #(
        .BUS_BYTES  (BUS_BYTES),
        .BIG_ENDIAN (BIG_ENDIAN),
        .WCNT_W     (WCNT_W),
        .BIDX_W     (BIDX_W)
    ) u_map (
        .word_idx (word_idx),
        .nwords   (nwords),
        .lane_idx (lane_idx)
    );

    wrs_gather #(
        .BUS_BYTES (BUS_BYTES),
        .REG_BYTES (REG_BYTES),
        .BIDX_W    (BIDX_W)
    ) u_gather (
        .clk       (clk),
        .rst       (rst),
        .clear     (load),
        .capture   (advance && !write_q),
        .lane_idx  (lane_idx),
        .bus_rdata (bus_rdata),
        .rd_data   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
            write_q <= 1'b0;
        end else if (load) begin
            wdata_q <= req_wdata;
            write_q <= req_write;
        end
    end

    assign bus_write = write_q;

    always_comb begin
        bus_wdata = '0;
        for (int i = 0; i < BUS_BYTES; i++)
            bus_wdata[i*8 +: 8] = wdata_q[lane_idx[i*BIDX_W +: BIDX_W]*8 +: 8];
    end
endmodule

// File: rtl/wide_reg_splitter_chk.sv
module wide_reg_splitter_chk #(
    parameter int BUS_BYTES = 4,
    parameter int ADDR_W    = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic                   busy,
    input logic                   done,
    input logic                   bus_valid,
    input logic                   bus_ready,
    input logic                   bus_write,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [8*BUS_BYTES-1:0] bus_wdata
);
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready) |=> (!bus_valid || bus_addr == $past(bus_addr) + ADDR_W'(BUS_BYTES))); // R3

    AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> busy); // R7

    AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_valid && bus_ready)); // R9

    AST_START_NEXT: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> (busy && bus_valid)); // R10
endmodule

bind wide_reg_splitter wide_reg_splitter_chk #(
    .BUS_BYTES (BUS_BYTES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/wide_reg_splitter_test.sv
module wide_reg_splitter_test;
    localparam int CLK_PERIOD = 10;
    localparam int BB  = 4;
    localparam int MW  = 4;
    localparam int AW  = 16;
    localparam int RW  = 8 * BB * MW;
    localparam int BW  = 8 * BB;
    localparam int SZW = $clog2(BB * MW + 1);

    typedef struct { logic [AW-1:0] addr; logic wr; logic [BW-1:0] data; } xfer_t;
    typedef struct { logic rd; logic [RW-1:0] data; } res_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic           req_valid = 1'b0;
    logic           req_write = 1'b0;
    logic [AW-1:0]  req_addr  = '0;
    logic [SZW-1:0] req_bytes = '0;
    logic [RW-1:0]  req_wdata = '0;

    logic          busy [2];
    logic          done [2];
    logic          bv   [2];
    logic          bw   [2];
    logic [AW-1:0] ba   [2];
    logic [BW-1:0] bwd  [2];
    logic [BW-1:0] brd  [2];
    logic [RW-1:0] rdd  [2];

    logic       bus_ready;
    logic       stall_on = 1'b0;
    logic [7:0] tick;
    logic [7:0] mem [2][256];

    xfer_t xq [2][$];
    res_t  rq [2][$];
    bit    pend [2];
    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;

    wide_reg_splitter #(.BUS_BYTES(BB), .MAX_WORDS(MW), .ADDR_W(AW), .BIG_ENDIAN(0)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
        .busy(busy[0]), .done(done[0]), .rd_data(rdd[0]),
        .bus_valid(bv[0]), .bus_write(bw[0]), .bus_addr(ba[0]), .bus_wdata(bwd[0]),
        .bus_ready(bus_ready), .bus_rdata(brd[0])
    );

    wide_reg_splitter #(.BUS_BYTES(BB), .MAX_WORDS(MW), .ADDR_W(AW), .BIG_ENDIAN(1)) uut_be (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
        .busy(busy[1]), .done(done[1]), .rd_data(rdd[1]),
        .bus_valid(bv[1]), .bus_write(bw[1]), .bus_addr(ba[1]), .bus_wdata(bwd[1]),
        .bus_ready(bus_ready), .bus_rdata(brd[1])
    );

    // bus responder: byte memory per instance, preloaded with addr ^ 5A
    always @(posedge clk) begin
        if (rst) begin
            tick <= '0;
            for (int x = 0; x < 2; x++)
                for (int j = 0; j < 256; j++)
                    mem[x][j] <= 8'(j) ^ 8'h5A;
        end else begin
            tick <= tick + 8'd1;
            for (int x = 0; x < 2; x++)
                if (bv[x] && bus_ready && bw[x])
                    for (int i = 0; i < BB; i++)
                        mem[x][8'(ba[x][7:0] + 8'(i))] <= bwd[x][i*8 +: 8];
        end
    end

    always_comb begin
        for (int x = 0; x < 2; x++)
            for (int i = 0; i < BB; i++)
                brd[x][i*8 +: 8] = mem[x][8'(ba[x][7:0] + 8'(i))];
    end

    assign bus_ready = !stall_on || (tick[1:0] != 2'd0);

    task automatic chk(input bit ok, input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !finished) begin
            for (int x = 0; x < 2; x++) begin
                if (pend[x]) begin
                    res_t r;
                    pend[x] = 0;
                    chk(done[x] == 1'b1, "R9 done one cycle after last transfer", RW'(done[x]), RW'(1));
                    if (rq[x].size() > 0) begin
                        r = rq[x].pop_front();
                        if (r.rd)
                            chk(rdd[x] == r.data, (x == 0) ? "R6 LE read gather" : "R6 BE read gather",
                                rdd[x], r.data);
                    end
                end else if (done[x]) begin
                    chk(1'b0, "R9 unexpected done", RW'(1), RW'(0));
                end
                if (bv[x] && bus_ready) begin
                    xfer_t e;
                    if (xq[x].size() == 0) begin
                        chk(1'b0, "R7 R2 extra transfer", RW'(ba[x]), RW'(0));
                    end else begin
                        e = xq[x].pop_front();
                        chk(ba[x] == e.addr, "R3 transfer address", RW'(ba[x]), RW'(e.addr));
                        chk(bw[x] == e.wr, "R2 write flag", RW'(bw[x]), RW'(e.wr));
                        if (e.wr)
                            chk(bwd[x] == e.data, (x == 0) ? "R4 LE lane data" : "R5 BE lane data",
                                RW'(bwd[x]), RW'(e.data));
                        if (xq[x].size() == 0) pend[x] = 1;
                    end
                end
            end
        end
    end

    // driver: pushes expected transfers and results, then issues the request
    task automatic issue(input bit wr, input logic [AW-1:0] addr, input int nbytes,
                         input logic [RW-1:0] data, input bit poke);
        int nw, t, pos, idx;
        xfer_t e;
        res_t  r;
        while (busy[0] || busy[1]) @(negedge clk);
        nw = (nbytes <= BB) ? 1 : nbytes / BB;
        t  = nw * BB;
        for (int x = 0; x < 2; x++) begin
            for (int k = 0; k < nw; k++) begin
                e.addr = addr + AW'(k * BB);
                e.wr   = wr;
                e.data = '0;
                for (int i = 0; i < BB; i++) begin
                    pos = k * BB + i;
                    idx = (x == 1) ? (t - 1 - pos) : pos;
                    e.data[i*8 +: 8] = data[idx*8 +: 8];
                end
                xq[x].push_back(e);
            end
            r.rd   = !wr;
            r.data = '0;
            for (int j = 0; j < t; j++)
                r.data[j*8 +: 8] = (x == 1) ? mem[x][8'(addr) + 8'(t - 1 - j)] : mem[x][8'(addr) + 8'(j)];
            rq[x].push_back(r);
        end
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_bytes = SZW'(nbytes);
        req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy[0] && bv[0] && busy[1] && bv[1], "R10 busy and bus_valid after request",
            RW'({busy[0], bv[0], busy[1], bv[1]}), RW'(4'hF));
        if (poke) begin
            req_valid = 1'b1;
            req_write = 1'b1;
            req_addr  = 16'h00C0;
            req_bytes = SZW'(4);
            req_wdata = '1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy[0] || busy[1]) @(negedge clk);
        @(negedge clk);
    endtask

    localparam logic [RW-1:0] W16 = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy[0] && !bv[0] && !done[0] && !busy[1] && !bv[1] && !done[1], "R1 reset idle",
            RW'({busy[0], bv[0], done[0], busy[1], bv[1], done[1]}), RW'(0));

        // full-width write, no wait states
        issue(1'b1, 16'h0010, 16, W16, 1'b0);
        chk(mem[0][8'h10] == W16[7:0],     "R4 LE lowest address holds LSB",  RW'(mem[0][8'h10]), RW'(W16[7:0]));
        chk(mem[0][8'h1F] == W16[127:120], "R4 LE highest address holds MSB", RW'(mem[0][8'h1F]), RW'(W16[127:120]));
        chk(mem[1][8'h10] == W16[127:120], "R5 BE lowest address holds MSB",  RW'(mem[1][8'h10]), RW'(W16[127:120]));
        chk(mem[1][8'h1F] == W16[7:0],     "R5 BE highest address holds LSB", RW'(mem[1][8'h1F]), RW'(W16[7:0]));

        // read back: round trip in both modes
        issue(1'b0, 16'h0010, 16, '0, 1'b0);
        chk(rdd[0] == W16, "R6 LE round trip", rdd[0], W16);
        chk(rdd[1] == W16, "R6 BE round trip", rdd[1], W16);

        // wait states on the bus (R8)
        stall_on = 1'b1;
        issue(1'b1, 16'h0040, 8, RW'(64'h1122334455667788), 1'b0);
        issue(1'b0, 16'h0020, 12, '0, 1'b0);
        issue(1'b0, 16'h0040, 8, '0, 1'b0);
        chk(rdd[0] == RW'(64'h1122334455667788), "R8 R6 LE read under stalls", rdd[0], RW'(64'h1122334455667788));

        // narrow register: one transfer (R2)
        issue(1'b1, 16'h0080, 2, RW'(16'hBEEF), 1'b0);
        chk(mem[0][8'h80] == 8'hEF && mem[1][8'h83] == 8'hEF, "R2 narrow single transfer placement",
            RW'({mem[0][8'h80], mem[1][8'h83]}), RW'(16'hEFEF));
        issue(1'b0, 16'h0084, 4, '0, 1'b0);
        stall_on = 1'b0;

        // request while busy must be ignored (R7)
        issue(1'b0, 16'h0010, 16, '0, 1'b1);
        chk(mem[0][8'hC0] == (8'hC0 ^ 8'h5A) && mem[1][8'hC0] == (8'hC0 ^ 8'h5A),
            "R7 request during busy ignored", RW'({mem[0][8'hC0], mem[1][8'hC0]}), RW'(16'h9A9A));
        chk(xq[0].size() == 0 && xq[1].size() == 0, "R2 all expected transfers seen",
            RW'(xq[0].size() + xq[1].size()), RW'(0));

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired R9 actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule